// File: doc/BRIEF.md
# Left Shifter with Selectable Count Interpretation

This block shifts an operand left by a count and fills the vacated low bits with zeros. It supports three ways of reading the count. In the wrap rule the count is reduced modulo the operand width. In the byte rule only the low eight bits of the count are used, and any such value at or above the width produces zero. In the saturate rule the whole count is used, and any count at or above the width produces zero. The block lets one datapath behave the way different processor conventions treat oversized shift counts.

Work enters as a single beat on a valid/ready stream that carries the operand, the count and the rule select. The result leaves on a second valid/ready stream after one register stage. The input accepts a beat when `in_valid` and `in_ready` are both high at a rising clock edge. The output transfers its beat when `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the block runs at one beat per cycle when the output is never blocked. If the output is held back, the block stops taking input. No beat is dropped and no beat is duplicated.

A shift by 0..width-1 is built as one 2:1 mux stage per count bit. Detection of an oversized count runs beside those stages, and a final stage picks between the shifted value and zero. The latency therefore does not depend on the count. The operand width `DATA_W` must be 32 or 64. `CNT_W` must be 8 or more.

Top module: `lsl_mask_shifter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: Rule 2'b00 (wrap): the result is `in_operand << (in_count mod DATA_W)`. A count of DATA_W gives the unshifted operand.
- R3: Rule 2'b11 behaves exactly like rule 2'b00.
- R4: Rule 2'b01 (byte): let b = `in_count[7:0]`. The result is `in_operand << b` when b < DATA_W and zero when b >= DATA_W. Count bits above bit 7 have no effect.
- R5: Rule 2'b10 (saturate): the result is zero whenever the full `in_count` value is >= DATA_W and does not wrap. Otherwise the result is `in_operand << in_count`.
- R6: A beat accepted at a clock edge shows up on `out_data` with `out_valid` high right after that same edge, for every count value.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R9: When the output beat is taken and no new beat is accepted at the same edge, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_operand | input | DATA_W | Value to shift |
| in_count | input | CNT_W | Shift count |
| in_mode | input | 2 | Count rule: 00 wrap, 01 byte, 10 saturate, 11 as 00 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Shifted result |

## Verification
The output register can be unloading a finished result at the same edge as it loads the next accepted beat. A result can also be held by back-pressure while a new beat is waiting at the input. The bench makes both cases happen by switching `out_ready` at random during long back-to-back streams, and by holding it low through directed stalls with a beat pending. A behavioural model tracks the expected occupancy, the value of `in_ready` and the expected data on every cycle. The design must not lose, repeat or change a result while it is stalled. It must also not leave a gap when a load and an unload happen in the same cycle.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

  // Count interpretation rules; the encoding is visible at the port.
  typedef enum logic [1:0] {
    RULE_WRAP  = 2'b00,
    RULE_BYTE  = 2'b01,
    RULE_SAT   = 2'b10,
    RULE_ALIAS = 2'b11
  } count_rule_e;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/lsl_count_decode.sv
module lsl_count_decode
  import lsl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       rule,
  output logic [SH_W-1:0]  amt,
  output logic             force_zero
);

  logic byte_over;
  logic full_over;

  // Oversize detection: any set bit at or above log2(width).
  assign byte_over = |count[BYTE_BITS-1:SH_W];
  assign full_over = |count[CNT_W-1:SH_W];

  // The low bits always steer the mux stages, whichever rule is active.
  assign amt = count[SH_W-1:0];

  always_comb begin
    unique case (count_rule_e'(rule))
      RULE_BYTE: force_zero = byte_over;
      RULE_SAT:  force_zero = full_over;
      default:   force_zero = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsl_stage_chain.sv
module lsl_stage_chain #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] lvl [SH_W+1];

  assign lvl[0] = din;

  // One 2:1 mux stage per count bit; stage s moves by 2**s positions.
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign lvl[s+1] = amt[s] ? (lvl[s] << STEP) : lvl[s];
  end

  assign dout = lvl[SH_W];

endmodule

// File: rtl/lsl_out_stage.sv
module lsl_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic [DATA_W-1:0] shifted,
  input  logic              force_zero,
  output logic              valid,
  output logic [DATA_W-1:0] data
);

  logic [DATA_W-1:0] picked;

  // Final select between the shifted value and zero.
  assign picked = force_zero ? '0 : shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= picked;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/lsl_mask_shifter.sv
module lsl_mask_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   amt;
  logic              force_zero;
  logic [DATA_W-1:0] shifted;
  logic              load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  lsl_count_decode #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) decode_i (
    .count     (in_count),
    .rule      (in_mode),
    .amt       (amt),
    .force_zero(force_zero)
  );

  lsl_stage_chain #(
    .DATA_W(DATA_W)
  ) chain_i (
    .din (in_operand),
    .amt (amt),
    .dout(shifted)
  );

  lsl_out_stage #(
    .DATA_W(DATA_W)
  ) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .drain     (out_ready),
    .shifted   (shifted),
    .force_zero(force_zero),
    .valid     (out_valid),
    .data      (out_data)
  );

endmodule

// File: rtl/lsl_mask_shifter_chk.sv
module lsl_mask_shifter_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_operand,
  input logic [CNT_W-1:0]  in_count,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);

  localparam int SH_W = $clog2(DATA_W);

  logic            acc;
  logic [SH_W-1:0] cnt_lo;
  logic [7:0]      cnt_byte;

  assign acc      = in_valid && in_ready;
  assign cnt_lo   = in_count[SH_W-1:0];
  assign cnt_byte = in_count[7:0];

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'b00) |=> out_data == ($past(in_operand) << $past(cnt_lo)));

  p_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'b11) |=> out_data == ($past(in_operand) << $past(cnt_lo)));

  p_byte_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'b01 && int'(cnt_byte) >= DATA_W) |=> out_data == '0);

  p_sat_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'b10 && int'(in_count) >= DATA_W) |=> out_data == '0);

endmodule

bind lsl_mask_shifter lsl_mask_shifter_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_operand(in_operand),
  .in_count  (in_count),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/lsl_mask_shifter_tb.sv
module lsl_mask_shifter_tb_top;

  localparam int DW = 32;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_operand = '0;
  logic [CW-1:0] in_count = '0;
  logic [1:0]    in_mode = 2'b00;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  int ready_mode = 0; // 0 always ready, 1 random, 2 blocked

  always #10 clk = ~clk;

  lsl_mask_shifter #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_count(in_count), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [DW-1:0] ref_shift(logic [DW-1:0] op, logic [CW-1:0] c, logic [1:0] m);
    int n;
    case (m)
      2'b01:   n = int'(c) % 256;
      2'b10:   n = int'(c);
      default: n = int'(c) % DW;
    endcase
    if (n >= DW) return '0;
    return op << n;
  endfunction

  function automatic string tag_of(logic [1:0] m);
    case (m)
      2'b00:   return "R2 wrap data";
      2'b11:   return "R3 alias data";
      2'b01:   return "R4 byte data";
      default: return "R5 saturate data";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: one-entry output slot
  bit            m_valid = 1'b0;
  bit            m_hold = 1'b0;
  logic [DW-1:0] m_data = '0;
  string         m_tag = "";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_hold  <= 1'b0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid <= 1'b1;
      m_hold  <= 1'b0;
      m_data  <= ref_shift(in_operand, in_count, in_mode);
      m_tag   <= tag_of(in_mode);
    end else if (out_ready) begin
      m_valid <= 1'b0;
      m_hold  <= 1'b0;
    end else begin
      m_hold  <= m_valid;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check("R8 in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      check(m_valid ? "R6 out_valid" : "R9 out_valid", 64'(out_valid), 64'(m_valid));
      if (m_valid && out_valid)
        check(m_hold ? "R7 held data" : m_tag, 64'(out_data), 64'(m_data));
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0:       out_ready <= 1'b1;
      1:       out_ready <= 1'($urandom_range(0, 1));
      default: out_ready <= 1'b0;
    endcase
  end

  task automatic send(logic [DW-1:0] op, logic [CW-1:0] c, logic [1:0] m);
    bit acc;
    in_valid   = 1'b1;
    in_operand = op;
    in_count   = c;
    in_mode    = m;
    forever begin
      #2 acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset out_valid", 64'(out_valid), 64'd0);
    check("R1 reset in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 post-reset out_valid", 64'(out_valid), 64'd0);
    @(negedge clk);

    // R2 wrap corners: 0, 1, 31, 32 wraps to 0, 33, 255
    send(32'h8000_0001, 12'd0,   2'b00);
    send(32'h8000_0001, 12'd1,   2'b00);
    send(32'h0000_0003, 12'd31,  2'b00);
    send(32'h0000_0003, 12'd32,  2'b00);
    send(32'h0000_0003, 12'd33,  2'b00);
    send(32'h1234_5678, 12'd255, 2'b00);
    // R3 alias of wrap
    send(32'h0000_0001, 12'd33,  2'b11);
    send(32'hABCD_EF01, 12'h7E4, 2'b11);
    // R4 byte rule: 31 shifts, 32 and 255 zero, 0x100 acts as 0, 0x120 zero
    send(32'h0000_0001, 12'd31,  2'b01);
    send(32'h0000_0001, 12'd32,  2'b01);
    send(32'hFFFF_FFFF, 12'd255, 2'b01);
    send(32'h0000_0005, 12'h100, 2'b01);
    send(32'h0000_0005, 12'h120, 2'b01);
    send(32'h0000_0005, 12'h103, 2'b01);
    // R5 saturate: 31 shifts, 32 zero, 0x100 zero (no wrap), 0x800 zero
    send(32'h0000_0001, 12'd31,  2'b10);
    send(32'h0000_0001, 12'd32,  2'b10);
    send(32'h0000_0007, 12'h100, 2'b10);
    send(32'h0000_0007, 12'h800, 2'b10);
    send(32'h0000_0007, 12'd4,   2'b10);
    repeat (2) @(negedge clk); // R9 drain with idle input

    // R7/R8 stall: result held while a second beat waits
    ready_mode = 2;
    send(32'h0000_00F0, 12'd4, 2'b00);
    fork
      send(32'h0000_000F, 12'd8, 2'b01);
      begin
        repeat (5) @(negedge clk);
        ready_mode = 0;
      end
    join
    repeat (3) @(negedge clk);

    // Random streams with random back-pressure
    ready_mode = 1;
    for (int i = 0; i < 400; i++) begin
      send(DW'($urandom), CW'($urandom), 2'($urandom));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    ready_mode = 0;
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule